// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each entry stores an address-space identifier (ASID) next to its virtual page number. The host uses ASID 0, and each guest gets its own nonzero ASID, so entries from all of them sit in the cache together. A lookup gives the current ASID and a virtual page. It hits only when a valid entry matches both. On a hit, the cached physical page comes back in the same cycle. When nested translation is active, that physical page is the final host page for a guest virtual page, because the walker has already combined both levels. A context switch only changes the ASID driven on the lookup port. Nothing is flushed.

On a miss, the block captures the (ASID, page) key and raises a refill request toward an external page walker. The request stays up until the walker returns a physical page. The response is a valid/ready stream:
- `rf_rsp_ready` is high exactly while a request is outstanding.
- A beat is consumed on the cycle both `rf_rsp_valid` and `rf_rsp_ready` are high.
- A walker that holds `rf_rsp_valid` while ready is low is simply stalled.
- The request payload stays stable for as long as `rf_req_valid` is high.

Only one request is outstanding at a time.

Invalidation takes one cycle. It either removes a single page within one ASID, or removes every entry of one ASID. The walk itself is outside this block.

Top module: `tagged_tlb`

## Requirements
- R1: After reset no entry is valid: `lk_hit` is 0 for any lookup, `rf_req_valid` is 0 and `rf_rsp_ready` is 0.
- R2: `lk_hit` is 1 in the same cycle as the lookup only when `lk_valid` is 1 and a valid entry holds both `lk_asid` and `lk_vpn`. `lk_ppn` then equals that entry's stored page. When `lk_valid` is 0, `lk_hit` is 0.
- R3: Entries with the same virtual page but different ASIDs (host ASID 0 and guest ASIDs) coexist and return their own pages. Changing the lookup ASID removes no entry.
- R4: A lookup miss with no outstanding request sets `rf_req_valid` from the next cycle, with `rf_req_asid`/`rf_req_vpn` equal to the missed key. These stay stable, and `rf_rsp_ready` stays 1, until a response beat is accepted.
- R5: An accepted response installs an entry with the requested key and `rf_rsp_ppn`. The entry is visible to lookups from the next cycle, and `rf_req_valid` drops in that same next cycle.
- R6: A refill goes into the lowest-indexed invalid entry. When all entries are valid, it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one (wrapping) on each such replacement.
- R7: `inv_valid`=1 with `inv_whole_asid`=0 removes only the entry matching both `inv_asid` and `inv_vpn`. All other entries stay.
- R8: `inv_valid`=1 with `inv_whole_asid`=1 removes every entry tagged `inv_asid` in one cycle. Entries of other ASIDs stay.
- R9: When a response beat and an invalidate occur in the same cycle, the invalidate is applied. The refill is discarded if its key is covered by that invalidate; otherwise both take effect. In either case the request completes.
- R10: Lookup misses while a request is outstanding do not start a new request and do not change the outstanding key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_asid | input | 8 | Current address-space identifier (0 = host) |
| lk_vpn | input | 20 | Virtual page of the lookup |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_ppn | output | 20 | Physical page of the hit (0 on miss) |
| rf_req_valid | output | 1 | Refill request outstanding |
| rf_req_asid | output | 8 | ASID of the outstanding request |
| rf_req_vpn | output | 20 | Virtual page of the outstanding request |
| rf_rsp_valid | input | 1 | Walker presents a response beat |
| rf_rsp_ready | output | 1 | Block accepts a response beat |
| rf_rsp_ppn | input | 20 | Final physical page from the walker |
| inv_valid | input | 1 | Invalidate command this cycle |
| inv_whole_asid | input | 1 | 1: remove all entries of inv_asid; 0: one page |
| inv_asid | input | 8 | ASID targeted by the invalidate |
| inv_vpn | input | 20 | Page targeted by a single-page invalidate |

## Verification
Some properties are checked on every cycle:
- at most one entry matches a lookup;
- no hit is reported without a lookup;
- the request payload holds while it is outstanding, and the request ends right after an accepted response;
- a free-entry victim is never an occupied entry;
- every entry covered by an invalidate, and not being rewritten, is invalid afterwards.

Other behaviours only the bench scenarios can show:
- round-robin eviction order once the cache is full;
- survival of same-page entries across ASIDs;
- the drop-or-install outcome when a response and an invalidate collide.

The bench shows these by later lookups compared against a reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_ENTRIES = 16;
  localparam int TLB_ASID_W  = 8;
  localparam int TLB_VPN_W   = 20;
  localparam int TLB_PPN_W   = 20;

  function automatic logic key_covered(input logic whole, input logic asid_eq, input logic vpn_eq);
    return asid_eq && (whole || vpn_eq);
  endfunction
endpackage

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q;
  logic             have_free;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign victim = have_free ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (take && !have_free) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else rr_q <= rr_q + 1'b1;
    end
  end

  // R6: a free slot is always preferred over an occupied one
  assert_victim_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(&valid_vec)) |-> !valid_vec[victim]);
  assert_rr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rr_q) < ENTRIES);
endmodule

// File: rtl/tlb_tag_store.sv
module tlb_tag_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_en,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic               inv_en,
  input  logic               inv_all,
  input  logic [ASID_W-1:0]  inv_asid,
  input  logic [VPN_W-1:0]   inv_vpn,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] valid_q;
  logic [ASID_W-1:0]  tag_asid [ENTRIES];
  logic [VPN_W-1:0]   tag_vpn  [ENTRIES];
  logic [PPN_W-1:0]   data_ppn [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] kill_vec;

  assign valid_vec = valid_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match_vec[g] = lk_en && valid_q[g] &&
                          (tag_asid[g] == lk_asid) && (tag_vpn[g] == lk_vpn);
    assign kill_vec[g]  = inv_en && valid_q[g] &&
                          key_covered(inv_all, tag_asid[g] == inv_asid, tag_vpn[g] == inv_vpn);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[g] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(g)) valid_q[g] <= 1'b1;
      else if (kill_vec[g]) valid_q[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        tag_asid[g] <= wr_asid;
        tag_vpn[g]  <= wr_vpn;
        data_ppn[g] <= wr_ppn;
      end
    end

    // R8: a whole-ASID flush leaves no live entry of that ASID
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && inv_all && valid_q[g] && tag_asid[g] == inv_asid &&
       !(wr_en && wr_idx == IDX_W'(g))) |=> !valid_q[g]);
    // R7: a page invalidate removes the matching entry
    assert_page_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && !inv_all && valid_q[g] && tag_asid[g] == inv_asid &&
       tag_vpn[g] == inv_vpn && !(wr_en && wr_idx == IDX_W'(g))) |=> !valid_q[g]);
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_vec[i]) lk_ppn = lk_ppn | data_ppn[i];
  end
  assign lk_hit = |match_vec;

  // R2: (ASID, page) keys are unique, so at most one entry matches
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES,
  parameter int ASID_W  = TLB_ASID_W,
  parameter int VPN_W   = TLB_VPN_W,
  parameter int PPN_W   = TLB_PPN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              rf_req_valid,
  output logic [ASID_W-1:0] rf_req_asid,
  output logic [VPN_W-1:0]  rf_req_vpn,
  input  logic              rf_rsp_valid,
  output logic              rf_rsp_ready,
  input  logic [PPN_W-1:0]  rf_rsp_ppn,
  input  logic              inv_valid,
  input  logic              inv_whole_asid,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VPN_W-1:0]  inv_vpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic               pend_q;
  logic [ASID_W-1:0]  pend_asid_q;
  logic [VPN_W-1:0]   pend_vpn_q;
  logic               rsp_fire;
  logic               rsp_dropped;
  logic               fill_en;
  logic [IDX_W-1:0]   fill_idx;
  logic [ENTRIES-1:0] valid_vec;

  assign rf_req_valid = pend_q;
  assign rf_req_asid  = pend_asid_q;
  assign rf_req_vpn   = pend_vpn_q;
  assign rf_rsp_ready = pend_q;
  assign rsp_fire     = rf_rsp_valid && pend_q;
  assign rsp_dropped  = inv_valid &&
                        key_covered(inv_whole_asid, pend_asid_q == inv_asid, pend_vpn_q == inv_vpn);
  assign fill_en      = rsp_fire && !rsp_dropped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_asid_q <= '0;
      pend_vpn_q  <= '0;
    end else if (rsp_fire) begin
      pend_q <= 1'b0;
    end else if (lk_valid && !lk_hit && !pend_q) begin
      pend_q      <= 1'b1;
      pend_asid_q <= lk_asid;
      pend_vpn_q  <= lk_vpn;
    end
  end

  tlb_tag_store #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_en    (lk_valid),
    .lk_asid  (lk_asid),
    .lk_vpn   (lk_vpn),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_asid  (pend_asid_q),
    .wr_vpn   (pend_vpn_q),
    .wr_ppn   (rf_rsp_ppn),
    .inv_en   (inv_valid),
    .inv_all  (inv_whole_asid),
    .inv_asid (inv_asid),
    .inv_vpn  (inv_vpn),
    .valid_vec(valid_vec)
  );

  tlb_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_vec(valid_vec),
    .take     (fill_en),
    .victim   (fill_idx)
  );

  // R2: no hit without a lookup
  assert_no_idle_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);
  // R4: request payload holds until a response beat is taken
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && !(rf_rsp_valid && rf_rsp_ready)) |=>
      (rf_req_valid && $stable(rf_req_asid) && $stable(rf_req_vpn)));
  // R5: an accepted response ends the request
  assert_rsp_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rsp_valid && rf_rsp_ready) |=> !rf_req_valid);
  // R10: no new request key while one is outstanding
  assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && !rf_rsp_valid) |=> $stable(rf_req_vpn));
endmodule

// File: tb/test_tagged_tlb.sv
`timescale 1ns/1ps
module test_tagged_tlb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_asid = '0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic        rf_req_valid;
  logic [7:0]  rf_req_asid;
  logic [19:0] rf_req_vpn;
  logic        rf_rsp_valid = 1'b0;
  logic        rf_rsp_ready;
  logic [19:0] rf_rsp_ppn = '0;
  logic        inv_valid = 1'b0;
  logic        inv_whole_asid = 1'b0;
  logic [7:0]  inv_asid = '0;
  logic [19:0] inv_vpn = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  bit          m_valid [N];
  logic [7:0]  m_asid  [N];
  logic [19:0] m_vpn   [N];
  logic [19:0] m_ppn   [N];
  int          m_rr = 0;
  bit          m_pend = 0;
  logic [7:0]  m_pasid = '0;
  logic [19:0] m_pvpn = '0;

  always #4 clk = ~clk;

  tagged_tlb i_tagged_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .rf_req_valid(rf_req_valid), .rf_req_asid(rf_req_asid), .rf_req_vpn(rf_req_vpn),
    .rf_rsp_valid(rf_rsp_valid), .rf_rsp_ready(rf_rsp_ready), .rf_rsp_ppn(rf_rsp_ppn),
    .inv_valid(inv_valid), .inv_whole_asid(inv_whole_asid),
    .inv_asid(inv_asid), .inv_vpn(inv_vpn)
  );

  function automatic int model_find(input logic [7:0] a, input logic [19:0] v);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_asid[i] == a && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int model_victim();
    for (int i = 0; i < N; i++)
      if (!m_valid[i]) return i;
    return m_rr;
  endfunction

  function automatic bit model_covers(input bit whole, input logic [7:0] ia, input logic [19:0] iv,
                                      input logic [7:0] a, input logic [19:0] v);
    return (a == ia) && (whole || v == iv);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, advance the model
  task automatic step(input string req,
                      input bit lv, input logic [7:0] la, input logic [19:0] lvpn,
                      input bit rv, input logic [19:0] rppn,
                      input bit iv, input bit iw, input logic [7:0] ia, input logic [19:0] ivpn);
    int  hit_i;
    bit  fire, drop, wr, full;
    int  vic;
    @(negedge clk);
    lk_valid = lv; lk_asid = la; lk_vpn = lvpn;
    rf_rsp_valid = rv; rf_rsp_ppn = rppn;
    inv_valid = iv; inv_whole_asid = iw; inv_asid = ia; inv_vpn = ivpn;
    #1;
    hit_i = lv ? model_find(la, lvpn) : -1;
    check(req, 32'(lk_hit), 32'(hit_i >= 0));
    if (hit_i >= 0) check(req, 32'(lk_ppn), 32'(m_ppn[hit_i]));
    check(req, 32'(rf_req_valid), 32'(m_pend));
    check(req, 32'(rf_rsp_ready), 32'(m_pend));
    if (m_pend) begin
      check(req, 32'(rf_req_asid), 32'(m_pasid));
      check(req, 32'(rf_req_vpn), 32'(m_pvpn));
    end
    fire = rv && m_pend;
    drop = fire && iv && model_covers(iw, ia, ivpn, m_pasid, m_pvpn);
    wr   = fire && !drop;
    vic  = model_victim();
    full = 1;
    for (int i = 0; i < N; i++) if (!m_valid[i]) full = 0;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (wr && i == vic) begin
        m_valid[i] = 1; m_asid[i] = m_pasid; m_vpn[i] = m_pvpn; m_ppn[i] = rppn;
      end else if (iv && m_valid[i] && model_covers(iw, ia, ivpn, m_asid[i], m_vpn[i])) begin
        m_valid[i] = 0;
      end
    end
    if (wr && full) m_rr = (m_rr + 1) % N;
    if (fire) m_pend = 0;
    else if (lv && hit_i < 0 && !m_pend) begin
      m_pend = 1; m_pasid = la; m_pvpn = lvpn;
    end
  endtask

  task automatic look(input string req, input logic [7:0] a, input logic [19:0] v);
    step(req, 1, a, v, 0, '0, 0, 0, '0, '0);
  endtask

  task automatic fill(input string req, input logic [7:0] a, input logic [19:0] v, input logic [19:0] p);
    look(req, a, v);
    step(req, 0, '0, '0, 1, p, 0, 0, '0, '0);
  endtask

  task automatic inval(input string req, input bit whole, input logic [7:0] a, input logic [19:0] v);
    step(req, 0, '0, '0, 0, '0, 1, whole, a, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd77);
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    look("R1", 8'd0, 20'h5);
    step("R1", 0, '0, '0, 0, '0, 0, 0, '0, '0);
    // R4/R10: request held; other misses ignored
    look("R10", 8'd2, 20'h9);
    look("R4", 8'd0, 20'h5);
    step("R5", 0, '0, '0, 1, 20'hA0005, 0, 0, '0, '0);
    look("R2", 8'd0, 20'h5);
    step("R2", 0, 8'd0, 20'h5, 0, '0, 0, 0, '0, '0);
    // R3: same page under host and guest ASIDs
    fill("R3", 8'd3, 20'h5, 20'hB0305);
    fill("R3", 8'd0, 20'h9, 20'hA0009);
    look("R3", 8'd0, 20'h5);
    look("R3", 8'd3, 20'h5);
    look("R3", 8'd0, 20'h5);
    // R6: fill to full, then round-robin evictions
    for (int k = 0; k < 14; k++) fill("R6", 8'd7, 20'(16'h100 + k), 20'(20'h70000 + k));
    fill("R6", 8'd9, 20'h1, 20'h90001);
    look("R6", 8'd0, 20'h5);
    look("R6", 8'd3, 20'h5);
    step("R6", 0, '0, '0, 1, 20'h90002, 0, 0, '0, '0);
    look("R6", 8'd3, 20'h5);
    look("R6", 8'd9, 20'h1);
    // R7: single page within one ASID
    inval("R7", 0, 8'd7, 20'h103);
    look("R7", 8'd7, 20'h103);
    step("R7", 0, '0, '0, 1, 20'h7FFFF, 0, 0, '0, '0);
    look("R7", 8'd7, 20'h104);
    // R8: whole ASID
    inval("R8", 1, 8'd7, '0);
    look("R8", 8'd7, 20'h105);
    step("R8", 0, '0, '0, 0, '0, 0, 0, '0, '0);
    look("R8", 8'd9, 20'h1);
    // R9: collisions
    look("R9", 8'd4, 20'h44);
    step("R9", 0, '0, '0, 1, 20'h44444, 1, 0, 8'd4, 20'h44);
    look("R9", 8'd4, 20'h44);
    step("R9", 0, '0, '0, 1, 20'h45454, 1, 1, 8'd9, '0);
    look("R9", 8'd4, 20'h44);
    look("R9", 8'd9, 20'h1);

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 6)
        look("R2", 8'($urandom_range(0, 3)), 20'($urandom_range(0, 11)));
      else if (op < 8)
        step("R9", 0, '0, '0, 1, 20'($urandom), ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
             8'($urandom_range(0, 3)), 20'($urandom_range(0, 11)));
      else
        inval("R7", 1'($urandom_range(0, 1)), 8'($urandom_range(0, 3)), 20'($urandom_range(0, 11)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule